// File: doc/BRIEF.md
# Horizontal Drive Soft-Start Controller

This block produces the horizontal drive pulse for a line-deflection stage. A line-rate timebase outside the block provides the pixel-tick position within the current line and a one-cycle strobe at the start of each line. The drive pulse goes high at the start of a line and stays high for a number of ticks set by a duty value. The duty value is a share of the line length.

When the drive starts, the duty is small, 2% of the line. It rises by an equal amount on every line until it reaches the working value of 55%, after the number of lines set by `RAMP_LINES` (300 by default). It then stays at 55%. This gradual start protects the output transistor while the supply settles. A standby bit holds the drive off for as long as it is set. An over-voltage trip or a power-on-reset pulse latches a fault that holds the drive off. Only a restart command clears that fault. Each time the drive comes back on, the ramp starts again from 2% at the next line start.

Top module: `hdrv_softstart`

## Requirements
- R1: While synchronous reset is high and afterwards, `hdrv` and `drive_on` are 0. Reset counts as a power-on event, so the drive stays off until a `resume_cmd` pulse arrives.
- R2: In the first line that begins at or after enabling, `hdrv` is high for floor(LINE_LEN*2/100) ticks. The pulse starts at line position 0. `hdrv` follows each sampled `line_pos` by one clock cycle.
- R3: In the k-th line after that first line, with k below RAMP_LINES, the high time is floor(LINE_LEN*(2*RAMP_LINES + 53*k)/(100*RAMP_LINES)) ticks.
- R4: From line RAMP_LINES onward, the high time is floor(LINE_LEN*55/100) and does not change.
- R5: The duty value changes only at a `line_start` strobe. If the drive is enabled in the middle of a line, `hdrv` stays low until the next line start.
- R6: If `standby` is high at a clock edge, `hdrv` and `drive_on` are 0 after that edge. Once `standby` goes low, the ramp restarts from 2% at the next line start.
- R7: An `ovp_trip` pulse turns the drive off at the next edge. The drive stays off after the trip input returns low, until a `resume_cmd` pulse.
- R8: A `por_pulse` turns the drive off at the next edge. The drive stays off until a `resume_cmd` pulse.
- R9: If a trip or power-on pulse arrives in the same cycle as `resume_cmd`, the fault wins and the drive stays off.
- R10: A `resume_cmd` given while `standby` is high clears the fault. The drive still stays off until `standby` goes low, and it then starts at 2%.
- R11: `drive_on` is registered. After each edge it is 1 exactly when no fault is latched and `standby` is low. `hdrv` is never high while `drive_on` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| line_pos | input | $clog2(LINE_LEN) | Tick position within the current line |
| line_start | input | 1 | One-cycle strobe when line_pos is 0 |
| standby | input | 1 | Hold the drive off while high |
| ovp_trip | input | 1 | Over-voltage trip, latches a fault |
| por_pulse | input | 1 | Power-on-reset detect, latches a fault |
| resume_cmd | input | 1 | Restart command strobe, clears a latched fault |
| hdrv | output | 1 | Horizontal drive pulse |
| drive_on | output | 1 | Drive enabled status |

## Verification
The bench goes after these corner cases:
- A trip that clears on its own. A design that does not latch the fault would turn the drive back on without a command.
- A trip in the same cycle as the restart command. A design with the priority reversed would turn the drive back on.
- A restart command given while in standby. A design that ignores the command there, or that ignores standby, would then start late or early.
- An enable in the middle of a line. This catches a design that starts a pulse mid-line.
- Re-entry after standby. This catches a design that keeps the old duty instead of restarting at 2%.
- The whole ramp up to its saturation line. This catches any error in the step size or its rounding, and an overshoot past 55%.

// File: rtl/hds_pkg.sv
package hds_pkg;

    localparam int unsigned START_PCT = 2;
    localparam int unsigned WORK_PCT  = 55;

    typedef enum logic [1:0] {
        DRV_FAULT   = 2'd0,
        DRV_STANDBY = 2'd1,
        DRV_ACTIVE  = 2'd2
    } drv_mode_e;

    typedef struct packed {
        logic fault;
        logic standby;
    } drv_cause_t;

    function automatic drv_mode_e mode_of(input drv_cause_t c);
        if (c.fault)
            return DRV_FAULT;
        else if (c.standby)
            return DRV_STANDBY;
        else
            return DRV_ACTIVE;
    endfunction

endpackage

// File: rtl/hds_protect.sv
module hds_protect
    import hds_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic standby,
    input  logic ovp_trip,
    input  logic por_pulse,
    input  logic resume_cmd,
    output logic en_d,
    output logic drive_on
);

    logic       fault_q;
    drv_cause_t cause_d;
    drv_mode_e  mode_d;

    always_comb begin
        // a new fault beats a restart command arriving in the same cycle
        cause_d.fault   = ovp_trip | por_pulse | (fault_q & ~resume_cmd);
        cause_d.standby = standby;
        mode_d          = mode_of(cause_d);
        en_d            = (mode_d == DRV_ACTIVE);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fault_q  <= 1'b1;
            drive_on <= 1'b0;
        end else begin
            fault_q  <= cause_d.fault;
            drive_on <= en_d;
        end
    end

endmodule

// File: rtl/hds_ramp.sv
module hds_ramp #(
    parameter int unsigned LINE_LEN   = 864,
    parameter int unsigned RAMP_LINES = 300,
    parameter int unsigned START_PCT  = 2,
    parameter int unsigned WORK_PCT   = 55,
    localparam int unsigned THR_W     = $clog2(LINE_LEN + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en_d,
    input  logic             line_start,
    output logic             run_d,
    output logic [THR_W-1:0] thr_d
);

    localparam longint DEN    = 100 * longint'(RAMP_LINES);
    localparam longint N0     = longint'(LINE_LEN) * START_PCT * RAMP_LINES;
    localparam longint STEP   = longint'(LINE_LEN) * (WORK_PCT - START_PCT);
    localparam int unsigned RW  = $clog2(2 * DEN);
    localparam int unsigned K_W = $clog2(RAMP_LINES + 1);

    localparam logic [THR_W-1:0] Q0     = THR_W'(N0 / DEN);
    localparam logic [RW-1:0]    R0     = RW'(N0 % DEN);
    localparam logic [THR_W-1:0] STEP_Q = THR_W'(STEP / DEN);
    localparam logic [RW-1:0]    STEP_R = RW'(STEP % DEN);
    localparam logic [RW-1:0]    DEN_V  = RW'(DEN);
    localparam logic [K_W-1:0]   K_MAX  = K_W'(RAMP_LINES);

    logic             run_q;
    logic [K_W-1:0]   k_q, k_d;
    logic [THR_W-1:0] q_q, q_d;
    logic [RW-1:0]    r_q, r_d, r_sum;

    always_comb begin
        run_d = run_q;
        k_d   = k_q;
        q_d   = q_q;
        r_d   = r_q;
        r_sum = r_q + STEP_R;
        if (!en_d) begin
            run_d = 1'b0;
            k_d   = '0;
            q_d   = Q0;
            r_d   = R0;
        end else if (line_start) begin
            if (!run_q) begin
                run_d = 1'b1;
                k_d   = '0;
                q_d   = Q0;
                r_d   = R0;
            end else if (k_q < K_MAX) begin
                k_d = k_q + 1'b1;
                if (r_sum >= DEN_V) begin
                    r_d = r_sum - DEN_V;
                    q_d = q_q + STEP_Q + 1'b1;
                end else begin
                    r_d = r_sum;
                    q_d = q_q + STEP_Q;
                end
            end
        end
        thr_d = q_d;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q <= 1'b0;
            k_q   <= '0;
            q_q   <= Q0;
            r_q   <= R0;
        end else begin
            run_q <= run_d;
            k_q   <= k_d;
            q_q   <= q_d;
            r_q   <= r_d;
        end
    end

endmodule

// File: rtl/hds_pulse.sv
module hds_pulse #(
    parameter int unsigned LINE_LEN = 864,
    localparam int unsigned POS_W   = $clog2(LINE_LEN),
    localparam int unsigned THR_W   = $clog2(LINE_LEN + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run_d,
    input  logic [THR_W-1:0] thr_d,
    input  logic [POS_W-1:0] line_pos,
    output logic             hdrv
);

    logic [THR_W-1:0] pos_x;

    always_comb pos_x = THR_W'(line_pos);

    always_ff @(posedge clk) begin
        if (rst)
            hdrv <= 1'b0;
        else
            hdrv <= run_d && (pos_x < thr_d);
    end

endmodule

// File: rtl/hdrv_softstart.sv
module hdrv_softstart
    import hds_pkg::*;
#(
    parameter int unsigned LINE_LEN   = 864,
    parameter int unsigned RAMP_LINES = 300
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [$clog2(LINE_LEN)-1:0] line_pos,
    input  logic                        line_start,
    input  logic                        standby,
    input  logic                        ovp_trip,
    input  logic                        por_pulse,
    input  logic                        resume_cmd,
    output logic                        hdrv,
    output logic                        drive_on
);

    localparam int unsigned THR_W = $clog2(LINE_LEN + 1);

    logic             en_d;
    logic             run_d;
    logic [THR_W-1:0] thr_d;

    hds_protect u_prot (
        .clk        (clk),
        .rst        (rst),
        .standby    (standby),
        .ovp_trip   (ovp_trip),
        .por_pulse  (por_pulse),
        .resume_cmd (resume_cmd),
        .en_d       (en_d),
        .drive_on   (drive_on)
    );

    hds_ramp #(
        .LINE_LEN   (LINE_LEN),
        .RAMP_LINES (RAMP_LINES),
        .START_PCT  (START_PCT),
        .WORK_PCT   (WORK_PCT)
    ) u_ramp (
        .clk        (clk),
        .rst        (rst),
        .en_d       (en_d),
        .line_start (line_start),
        .run_d      (run_d),
        .thr_d      (thr_d)
    );

    hds_pulse #(
        .LINE_LEN (LINE_LEN)
    ) u_pulse (
        .clk      (clk),
        .rst      (rst),
        .run_d    (run_d),
        .thr_d    (thr_d),
        .line_pos (line_pos),
        .hdrv     (hdrv)
    );

endmodule

// File: rtl/hds_checker.sv
module hds_checker #(
    parameter int unsigned LINE_LEN = 864
) (
    input logic                        clk,
    input logic                        rst,
    input logic [$clog2(LINE_LEN)-1:0] line_pos,
    input logic                        standby,
    input logic                        ovp_trip,
    input logic                        por_pulse,
    input logic                        resume_cmd,
    input logic                        hdrv,
    input logic                        drive_on
);

    p_standby_off_r6: assert property (@(posedge clk) disable iff (rst)
        standby |=> (!hdrv && !drive_on));

    p_trip_off_r7: assert property (@(posedge clk) disable iff (rst)
        ovp_trip |=> (!hdrv && !drive_on));

    p_trip_latched_r7: assert property (@(posedge clk) disable iff (rst)
        (ovp_trip ##1 (!resume_cmd && !rst)) |=> !drive_on);

    p_por_off_r8: assert property (@(posedge clk) disable iff (rst)
        por_pulse |=> (!hdrv && !drive_on));

    p_fault_wins_r9: assert property (@(posedge clk) disable iff (rst)
        ((ovp_trip || por_pulse) && resume_cmd) |=> !drive_on);

    p_hdrv_needs_on_r11: assert property (@(posedge clk) disable iff (rst)
        hdrv |-> drive_on);

    p_pulse_at_line_head_r5: assert property (@(posedge clk) disable iff (rst)
        (!hdrv ##1 hdrv) |-> ($past(line_pos) == '0));

endmodule

bind hdrv_softstart hds_checker #(.LINE_LEN(LINE_LEN)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .line_pos   (line_pos),
    .standby    (standby),
    .ovp_trip   (ovp_trip),
    .por_pulse  (por_pulse),
    .resume_cmd (resume_cmd),
    .hdrv       (hdrv),
    .drive_on   (drive_on)
);

// File: tb/hdrv_softstart_tb.sv
module hdrv_softstart_tb;

    localparam int CLK_PERIOD = 10;
    localparam int L_LEN      = 100;
    localparam int N_RAMP     = 300;
    localparam int POS_W      = $clog2(L_LEN);

    typedef struct {
        bit    exp_hdrv;
        bit    exp_on;
        string tag;
    } item_t;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [POS_W-1:0] line_pos = '0;
    logic             line_start = 1'b0;
    logic             standby = 1'b0;
    logic             ovp_trip = 1'b0;
    logic             por_pulse = 1'b0;
    logic             resume_cmd = 1'b0;
    logic             hdrv;
    logic             drive_on;

    int    n_vec = 0;
    int    n_bad = 0;
    item_t sb_q[$];

    // bench-side reference state
    bit    m_fault = 1'b1;
    bit    m_run   = 1'b0;
    int    m_k     = 0;
    int    pos     = 0;
    bit    stby    = 1'b0;
    bit    ramp_tags = 1'b0;
    string tag     = "R1";
    bit    done    = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    hdrv_softstart #(.LINE_LEN(L_LEN), .RAMP_LINES(N_RAMP)) u_dut (
        .clk        (clk),
        .rst        (rst),
        .line_pos   (line_pos),
        .line_start (line_start),
        .standby    (standby),
        .ovp_trip   (ovp_trip),
        .por_pulse  (por_pulse),
        .resume_cmd (resume_cmd),
        .hdrv       (hdrv),
        .drive_on   (drive_on)
    );

    function automatic int ticks_for(int k);
        longint num;
        num = longint'(L_LEN) * (2 * N_RAMP + 53 * k);
        return int'(num / (100 * N_RAMP));
    endfunction

    task automatic report(string t, string what, int act, int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            if (n_bad <= 20)
                $display("FAIL %s %s actual=%0d expected=%0d (t=%0t)", t, what, act, exp, $time);
        end
    endtask

    // driver: applies one cycle of stimulus and predicts the result
    task automatic step(input bit trip, input bit por, input bit res);
        item_t it;
        bit    ls;
        bit    en;
        @(negedge clk);
        ls         = (pos == 0);
        line_pos   = POS_W'(pos);
        line_start = ls;
        standby    = stby;
        ovp_trip   = trip;
        por_pulse  = por;
        resume_cmd = res;
        m_fault = trip | por | (m_fault & ~res);
        en      = !m_fault && !stby;
        if (!en) begin
            m_run = 1'b0;
            m_k   = 0;
        end else if (ls) begin
            if (!m_run) begin
                m_run = 1'b1;
                m_k   = 0;
            end else if (m_k < N_RAMP) begin
                m_k++;
            end
        end
        it.exp_hdrv = m_run && (pos < ticks_for(m_k));
        it.exp_on   = en;
        if (ramp_tags)
            it.tag = !m_run ? "R5" : (m_k == 0 ? "R2" : (m_k < N_RAMP ? "R3" : "R4"));
        else
            it.tag = tag;
        sb_q.push_back(it);
        pos = (pos == L_LEN - 1) ? 0 : pos + 1;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1'b0, 1'b0, 1'b0);
    endtask

    task automatic to_pos(input int p);
        while (pos != p) step(1'b0, 1'b0, 1'b0);
    endtask

    // monitor: compares the design against the queued predictions
    initial begin
        item_t it;
        forever begin
            @(posedge clk);
            #1;
            if (!rst && sb_q.size() > 0) begin
                it = sb_q.pop_front();
                report(it.tag, "hdrv", int'(hdrv), int'(it.exp_hdrv));
                report("R11", "drive_on", int'(drive_on), int'(it.exp_on));
            end
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        #1;
        // R1: reset state
        report("R1", "hdrv in reset", int'(hdrv), 0);
        report("R1", "drive_on in reset", int'(drive_on), 0);
        @(negedge clk);
        rst = 1'b0;

        // R1: stays off with no restart command
        tag = "R1";
        idle(2 * L_LEN + 7);

        // R2..R5: restart mid-line, then the full ramp to saturation
        ramp_tags = 1'b1;
        step(1'b0, 1'b0, 1'b1);
        idle((N_RAMP + 6) * L_LEN);
        ramp_tags = 1'b0;

        // R6: standby mid-line, released mid-line, restart from 2%
        tag = "R6";
        to_pos(1);
        stby = 1'b1;
        idle(3 * L_LEN + 20);
        stby = 1'b0;
        idle(12 * L_LEN);

        // R7: trip that clears by itself stays latched
        tag = "R7";
        to_pos(1);
        step(1'b1, 1'b0, 1'b0);
        step(1'b1, 1'b0, 1'b0);
        idle(3 * L_LEN);
        step(1'b0, 1'b0, 1'b1);
        idle(5 * L_LEN);

        // R8: power-on pulse
        tag = "R8";
        to_pos(40);
        step(1'b0, 1'b1, 1'b0);
        idle(2 * L_LEN);
        step(1'b0, 1'b0, 1'b1);
        idle(4 * L_LEN);

        // R9: fault in the same cycle as the restart command
        tag = "R9";
        to_pos(0);
        step(1'b1, 1'b0, 1'b1);
        idle(2 * L_LEN);
        step(1'b0, 1'b1, 1'b1);
        idle(L_LEN);
        step(1'b0, 1'b0, 1'b1);
        idle(3 * L_LEN);

        // R10: restart command while in standby
        tag = "R10";
        stby = 1'b1;
        step(1'b0, 1'b1, 1'b0);
        idle(L_LEN);
        step(1'b0, 1'b0, 1'b1);
        idle(L_LEN + 30);
        stby = 1'b0;
        idle(4 * L_LEN);

        wait (sb_q.size() == 0);
        @(posedge clk);
        #2;
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule